// File: doc/BRIEF.md
# Multiprocessor Interrupt Level Controller

This block collects raw interrupt requests from on-board devices, expansion-bus and backplane slots, asynchronous error detectors and per-CPU tick timers. It adds one software interrupt word per CPU and turns all of these into a 4-bit processor interrupt level (PIL) for each of up to `NCPU` processors. Many sources share a level, and each source has its own mask bit. A fixed, irregular table gives every source its level. Device interrupts go to one selected CPU. Asynchronous errors reach every CPU.

Software reaches the block through a flat, single-cycle register port. Writes take effect on the clock edge. Reads are combinational. Address bits [5:3] select a bank: value 7 is the global bank, and values 0 to `NCPU-1` are the per-CPU banks. Bits [2:0] select a word within the bank. The global bank words are: 0 pending, 1 mask, 2 mask-clear, 3 mask-set, 4 target. The per-CPU bank words are: 0 pending, 1 clear, 2 set. The PIL outputs are combinational from the register state and the request inputs.

Top module: `mp_irq_level_ctrl`

## Requirements
- R1: After reset, the global mask word reads 0xF87FFFFF and the target word reads 0. Every per-CPU software bit is 0. Every `cpu_pil` lane is 0 whatever the request inputs.
- R2: A write to global word 3 (mask-set) sets each implemented mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R3: A write to global word 2 (mask-clear) clears each mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R4: Global word 0 returns the raw `irq_src` bits 30..27 and 22..0, whatever the mask. Bits 31 and 26..23 read as 0.
- R5: In a per-CPU bank, a write to word 2 raises, and a write to word 1 drops, the software level-n request (n = 1..15) held at bit 16+n. Word 0 returns those bits at 31..17, the CPU's `cpu_tick` at bit 7, and 0 elsewhere.
- R6: Unmasked sources map to levels as follows. Level 2 takes bit 7 and bit 0. Level 3 takes bits 8 and 1. Level 4 takes bit 18. Level 5 takes bits 9 and 2. Level 6 takes bit 16. Level 7 takes bits 10 and 3. Level 8 takes bit 20. Level 9 takes bits 11, 4 and 21. Level 10 takes bit 19. Level 11 takes bits 12, 5 and 22. Level 12 takes bits 15 and 14. Level 13 takes bits 13, 6 and 17. Level 14 is the CPU's own `cpu_tick`, which has no individual mask bit.
- R7: Device sources (bits 22..0) reach only the CPU whose number is held in global word 4. That word is written from the low bits of the data.
- R8: Any unmasked error source (bits 30..27) gives level 15 on every CPU at once.
- R9: While mask bit 31 is 1, all device sources, error sources and tick requests are blocked. Software requests still reach their CPU.
- R10: Each CPU's PIL is the highest level among its active requests, and 0 when it has none.
- R11: Writes to global words 0 and 1 and to per-CPU word 0 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 6 | Bank in [5:3], word in [2:0] |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_src | input | 32 | Raw device and error request lines, in the global bit layout |
| cpu_tick | input | NCPU | Per-CPU level-14 timer request |
| cpu_pil | output | 4*NCPU | Interrupt level per CPU, CPU c at bits [4c+3:4c] |

## Verification
The bench builds the block with its default `NCPU = 4`. With that value the target field is exactly two bits wide, so every value written into it names a real CPU. Routing can therefore be checked for each of the four processors, and the broadcast of errors is seen on all four lanes together. Four CPUs also let one lane carry a software request while another carries a routed device request. This exposes any leak of a request across lanes.

// File: rtl/mpic_pkg.sv
// Package: shared constants and the fixed source-to-level table of the
// interrupt level controller. Assumes a 32-bit register data path.
package mpic_pkg;

    localparam int          DATA_W      = 32;
    localparam int          LVL_W       = 4;
    localparam int          BANK_W      = 3;
    localparam int          WORD_W      = 3;
    localparam logic [2:0]  GLOBAL_BANK = 3'd7;

    // Global bank word indices (order is part of the programming model)
    localparam logic [2:0]  GW_PEND   = 3'd0;
    localparam logic [2:0]  GW_MASK   = 3'd1;
    localparam logic [2:0]  GW_UNMASK = 3'd2;
    localparam logic [2:0]  GW_SETMSK = 3'd3;
    localparam logic [2:0]  GW_TARGET = 3'd4;

    // Per-CPU bank word indices
    localparam logic [2:0]  CW_PEND  = 3'd0;
    localparam logic [2:0]  CW_DROP  = 3'd1;
    localparam logic [2:0]  CW_RAISE = 3'd2;

    localparam int          HOLD_ALL_BIT = 31;
    localparam int          TICK_BIT     = 7;
    localparam logic [31:0] MASK_IMPL    = 32'hF87F_FFFF;
    localparam logic [31:0] SRC_IMPL     = 32'h787F_FFFF;
    localparam logic [31:0] ERR_BITS     = 32'h7800_0000;

    // Level vector (bit n = level n) raised by active device bits 22..0.
    function automatic logic [15:0] dev_levels(input logic [31:0] act);
        logic [15:0] lv;
        lv = '0;
        // Slot lines: expansion level k at bit 6+k, backplane level k at bit k-1
        for (int k = 1; k <= 7; k++) begin
            lv[(k == 1) ? 2 : 2 * k - 1] |= act[6 + k] | act[k - 1];
        end
        lv[4]  |= act[18];
        lv[6]  |= act[16];
        lv[8]  |= act[20];
        lv[9]  |= act[21];
        lv[10] |= act[19];
        lv[11] |= act[22];
        lv[12] |= act[15] | act[14];
        lv[13] |= act[17];
        return lv;
    endfunction

endpackage

// File: rtl/mpic_global_regs.sv
// Global state: the source mask and the device target CPU.
// Assumes the strobes are mutually exclusive (decoded from one address).
module mpic_global_regs
    import mpic_pkg::*;
#(
    parameter int TGT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mask_set,
    input  logic              wr_mask_clr,
    input  logic              wr_target,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] mask_q,
    output logic [TGT_W-1:0]  target_q
);

    // Mask register: write-one-to-set and write-one-to-clear aliases
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= MASK_IMPL;
        else if (wr_mask_set)
            mask_q <= (mask_q | wr_data) & MASK_IMPL;
        else if (wr_mask_clr)
            mask_q <= mask_q & ~wr_data;
    end

    // Target register: CPU number that receives device interrupts
    always_ff @(posedge clk) begin
        if (!rst_n)
            target_q <= '0;
        else if (wr_target)
            target_q <= wr_data[TGT_W-1:0];
    end

    a_r2_set_masks: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask_set |=> ((mask_q & $past(wr_data & MASK_IMPL)) == $past(wr_data & MASK_IMPL)));

    a_r3_clear_unmasks: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask_clr |=> ((mask_q & $past(wr_data)) == '0));

    a_r3_zero_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask_set || wr_mask_clr) |=> ((mask_q & ~$past(wr_data)) == ($past(mask_q) & ~$past(wr_data))));

    a_r11_mask_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_mask_set || wr_mask_clr) |=> $stable(mask_q));

endmodule

// File: rtl/mpic_soft_bank.sv
// One CPU's software interrupt word: level n held at index n.
// Assumes raise and drop are never strobed in the same cycle.
module mpic_soft_bank (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_raise,
    input  logic        wr_drop,
    input  logic [15:1] wr_bits,
    output logic [15:1] soft_q
);

    // Software request bits: write-one-to-raise / write-one-to-drop
    always_ff @(posedge clk) begin
        if (!rst_n)
            soft_q <= '0;
        else if (wr_raise)
            soft_q <= soft_q | wr_bits;
        else if (wr_drop)
            soft_q <= soft_q & ~wr_bits;
    end

    a_r5_raise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wr_raise |=> ((soft_q & $past(wr_bits)) == $past(wr_bits)));

    a_r5_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drop |=> ((soft_q & $past(wr_bits)) == '0));

    a_r11_soft_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_raise || wr_drop) |=> $stable(soft_q));

endmodule

// File: rtl/mpic_level_enc.sv
// Priority encoder: highest set level of a vector (bit n = level n).
// Assumes bit 0 of the vector is tied low by the caller.
module mpic_level_enc
    import mpic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:0]      lvl_vec,
    output logic [LVL_W-1:0] pil
);

    // Scan upward so the last hit is the highest level
    always_comb begin
        pil = '0;
        for (int l = 1; l < 16; l++) begin
            if (lvl_vec[l]) pil = LVL_W'(l);
        end
    end

    a_r10_level_is_active: assert property (@(posedge clk) disable iff (!rst_n)
        (pil != '0) |-> lvl_vec[pil]);

    a_r10_none_higher: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_vec >> pil) <= 16'd1);

endmodule

// File: rtl/mp_irq_level_ctrl.sv
// Multiprocessor interrupt level controller top. Decodes the register
// port, masks and routes sources, and drives one PIL per CPU.
// Assumes NCPU <= 7 (bank 7 is the global bank).
module mp_irq_level_ctrl
    import mpic_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [5:0]             reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    input  logic [31:0]            irq_src,
    input  logic [NCPU-1:0]        cpu_tick,
    output logic [4*NCPU-1:0]      cpu_pil
);

    localparam int TGT_W = (NCPU > 1) ? $clog2(NCPU) : 1;

    logic [BANK_W-1:0] bank;
    logic [WORD_W-1:0] word;
    logic              g_wr;
    logic [31:0]       mask_q;
    logic [TGT_W-1:0]  target_q;
    logic [31:0]       active;
    logic              hold_all;
    logic              err_any;
    logic [15:0]       dev_lv;
    logic [15:1]       soft_q [NCPU];

    assign bank = reg_addr[5:3];
    assign word = reg_addr[2:0];
    assign g_wr = reg_wr && (bank == GLOBAL_BANK);

    mpic_global_regs #(.TGT_W(TGT_W)) u_global (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_mask_set (g_wr && (word == GW_SETMSK)),
        .wr_mask_clr (g_wr && (word == GW_UNMASK)),
        .wr_target   (g_wr && (word == GW_TARGET)),
        .wr_data     (reg_wdata),
        .mask_q      (mask_q),
        .target_q    (target_q)
    );

    // Source gating: implemented, individually unmasked, and not held by mask-all
    always_comb begin
        hold_all = mask_q[HOLD_ALL_BIT];
        active   = irq_src & SRC_IMPL & ~mask_q & {32{~hold_all}};
        err_any  = |(active & ERR_BITS);
        dev_lv   = dev_levels(active);
    end

    for (genvar g = 0; g < NCPU; g++) begin : g_cpu
        logic        c_wr;
        logic [15:0] lvl_vec;

        assign c_wr = reg_wr && (bank == BANK_W'(g));

        mpic_soft_bank u_soft (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_raise (c_wr && (word == CW_RAISE)),
            .wr_drop  (c_wr && (word == CW_DROP)),
            .wr_bits  (reg_wdata[31:17]),
            .soft_q   (soft_q[g])
        );

        // Merge software, routed device, broadcast error and local tick requests
        always_comb begin
            lvl_vec = {soft_q[g], 1'b0};
            if (target_q == TGT_W'(g)) lvl_vec = lvl_vec | dev_lv;
            lvl_vec[15] = lvl_vec[15] | err_any;
            lvl_vec[14] = lvl_vec[14] | (cpu_tick[g] & ~hold_all);
        end

        mpic_level_enc u_enc (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl_vec (lvl_vec),
            .pil     (cpu_pil[4*g +: 4])
        );

        a_r8_error_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
            err_any |-> (cpu_pil[4*g +: 4] == 4'd15));

        a_r9_hold_keeps_soft_only: assert property (@(posedge clk) disable iff (!rst_n)
            hold_all |-> (cpu_pil[4*g +: 4] == 4'd0 || soft_q[g][cpu_pil[4*g +: 4]]));
    end

    // Read mux: raw pending, mask, target and per-CPU pending words
    always_comb begin
        reg_rdata = '0;
        if (bank == GLOBAL_BANK) begin
            case (word)
                GW_PEND:   reg_rdata = irq_src & SRC_IMPL;
                GW_MASK:   reg_rdata = mask_q;
                GW_TARGET: reg_rdata = 32'(target_q);
                default:   reg_rdata = '0;
            endcase
        end else begin
            for (int c = 0; c < NCPU; c++) begin
                if (bank == BANK_W'(c) && word == CW_PEND) begin
                    reg_rdata = {soft_q[c], 17'b0};
                    reg_rdata[TICK_BIT] = cpu_tick[c];
                end
            end
        end
    end

endmodule

// File: tb/mp_irq_level_ctrl_bench.sv
module mp_irq_level_ctrl_bench;

    localparam int NCPU = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [5:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [31:0]       irq_src = '0;
    logic [NCPU-1:0]   cpu_tick = '0;
    logic [4*NCPU-1:0] cpu_pil;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model
    logic [31:0] m_mask;
    logic [1:0]  m_tgt;
    logic [15:1] m_soft [NCPU];

    always #5 clk = ~clk;

    mp_irq_level_ctrl #(.NCPU(NCPU)) u_mp_irq_level_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_src(irq_src),
        .cpu_tick(cpu_tick), .cpu_pil(cpu_pil)
    );

    function automatic int level_of_bit(int b);
        case (b)
            0, 7:          return 2;
            1, 8:          return 3;
            18:            return 4;
            2, 9:          return 5;
            16:            return 6;
            3, 10:         return 7;
            20:            return 8;
            4, 11, 21:     return 9;
            19:            return 10;
            5, 12, 22:     return 11;
            14, 15:        return 12;
            6, 13, 17:     return 13;
            27, 28, 29, 30: return 15;
            default:       return 0;
        endcase
    endfunction

    function automatic int exp_pil(int cpu);
        int best = 0;
        if (!m_mask[31]) begin
            for (int b = 0; b < 31; b++) begin
                int l = level_of_bit(b);
                if (irq_src[b] && !m_mask[b] && l != 0 && (l == 15 || m_tgt == 2'(cpu)))
                    if (l > best) best = l;
            end
            if (cpu_tick[cpu] && best < 14) best = 14;
        end
        for (int n = 1; n < 16; n++)
            if (m_soft[cpu][n] && n > best) best = n;
        return best;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_pils(input string req);
        #1;
        for (int c = 0; c < NCPU; c++) begin
            logic [3:0] got = cpu_pil[4*c +: 4];
            chk(got == 4'(exp_pil(c)), req, 32'(got), 32'(exp_pil(c)));
        end
    endtask

    // Write one word and update the model from the register map
    task automatic wr(input logic [2:0] bnk, input logic [2:0] wd, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = {bnk, wd}; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (bnk == 3'd7) begin
            if (wd == 3'd3) m_mask = (m_mask | d) & 32'hF87F_FFFF;
            if (wd == 3'd2) m_mask = m_mask & ~d;
            if (wd == 3'd4) m_tgt = d[1:0];
        end else if (bnk < 3'(NCPU)) begin
            if (wd == 3'd2) m_soft[bnk] = m_soft[bnk] | d[31:17];
            if (wd == 3'd1) m_soft[bnk] = m_soft[bnk] & ~d[31:17];
        end
    endtask

    task automatic rd(input logic [2:0] bnk, input logic [2:0] wd, output logic [31:0] d);
        reg_addr = {bnk, wd};
        #1;
        d = reg_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED_1234));
        m_mask = 32'hF87F_FFFF;
        m_tgt  = '0;
        for (int c = 0; c < NCPU; c++) m_soft[c] = '0;

        irq_src  = 32'hFFFF_FFFF;
        cpu_tick = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd7, 3'd1, d); chk(d == 32'hF87F_FFFF, "R1 mask reset", d, 32'hF87F_FFFF);
        rd(3'd7, 3'd4, d); chk(d == 32'h0, "R1 target reset", d, 0);
        rd(3'd1, 3'd0, d); chk(d == 32'h0, "R1 soft reset", d, 0);
        #1; chk(cpu_pil == '0, "R1 pil reset", 32'(cpu_pil), 0);

        // R4 pending is raw while masked
        rd(3'd7, 3'd0, d); chk(d == 32'h787F_FFFF, "R4 raw pending", d, 32'h787F_FFFF);

        // R3 / R8: unmask everything -> errors broadcast level 15
        wr(3'd7, 3'd2, 32'hFFFF_FFFF);
        rd(3'd7, 3'd1, d); chk(d == 32'h0, "R3 mask cleared", d, 0);
        #1; chk(cpu_pil == 16'hFFFF, "R8 broadcast", 32'(cpu_pil), 32'hFFFF);

        // R2 / R7: mask errors, route devices to CPU 2
        wr(3'd7, 3'd3, 32'h7800_0000);
        rd(3'd7, 3'd1, d); chk(d == 32'h7800_0000, "R2 mask set", d, 32'h7800_0000);
        #1; chk(cpu_pil == 16'h000D, "R7 target 0", 32'(cpu_pil), 32'h000D);
        wr(3'd7, 3'd4, 32'h0000_0002);
        #1; chk(cpu_pil == 16'h0D00, "R7 target 2", 32'(cpu_pil), 32'h0D00);
        wr(3'd7, 3'd4, 32'h0);

        // R6 each source bit alone
        for (int b = 0; b < 23; b++) begin
            irq_src = 32'h1 << b;
            #1;
            chk(cpu_pil[3:0] == 4'(level_of_bit(b)), "R6 level map", 32'(cpu_pil[3:0]), 32'(level_of_bit(b)));
        end
        irq_src = '0; cpu_tick = 4'b0010;
        #1; chk(cpu_pil == 16'h00E0, "R6 tick level 14", 32'(cpu_pil), 32'h00E0);

        // R10 highest wins
        irq_src = (32'h1 << 18) | (32'h1 << 13);
        wr(3'd0, 3'd2, 32'h1 << 22);
        #1; chk(cpu_pil[3:0] == 4'd13, "R10 highest", 32'(cpu_pil[3:0]), 13);

        // R9 mask-all blocks hardware, soft survives
        irq_src = 32'hFFFF_FFFF; cpu_tick = '1;
        wr(3'd7, 3'd3, 32'h8000_0000);
        wr(3'd1, 3'd2, 32'h1 << 21);
        #1; chk(cpu_pil == 16'h0056, "R9 hold all", 32'(cpu_pil), 32'h0056);

        // R5 per-CPU pending layout and drop
        rd(3'd1, 3'd0, d); chk(d == 32'h0020_0080, "R5 cpu pending", d, 32'h0020_0080);
        wr(3'd1, 3'd1, 32'h1 << 21);
        rd(3'd1, 3'd0, d); chk(d == 32'h0000_0080, "R5 drop", d, 32'h0000_0080);

        // R11 writes to pending / mask words ignored
        wr(3'd7, 3'd0, 32'h0);
        wr(3'd7, 3'd1, 32'h0);
        rd(3'd7, 3'd1, d); chk(d == m_mask, "R11 mask untouched", d, m_mask);
        wr(3'd0, 3'd0, 32'h0);
        rd(3'd0, 3'd0, d); chk(d == 32'h0040_0080, "R11 soft untouched", d, 32'h0040_0080);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op = $urandom_range(0, 6);
            logic [31:0] r = $urandom() & $urandom();
            logic [2:0] cc = 3'($urandom_range(0, NCPU - 1));
            case (op)
                0: wr(3'd7, 3'd3, r & 32'h7FFF_FFFF);
                1: wr(3'd7, 3'd2, $urandom() | 32'h8000_0000);
                2: wr(3'd7, 3'd4, $urandom());
                3: wr(cc, 3'd2, r);
                4: wr(cc, 3'd1, $urandom());
                5: wr(3'd7, 3'($urandom_range(0, 1)), $urandom());
                default: begin
                    irq_src = $urandom() & $urandom() & $urandom();
                    cpu_tick = 4'($urandom());
                end
            endcase
            chk_pils("R10 random");
            rd(3'd7, 3'd1, d); chk(d == m_mask, "R2 random mask", d, m_mask);
            rd(cc, 3'd0, d);
            chk(d == ({m_soft[cc], 17'b0} | (32'(cpu_tick[cc]) << 7)), "R5 random pending", d,
                {m_soft[cc], 17'b0} | (32'(cpu_tick[cc]) << 7));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule